// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns a 6-bit operand specifier of a 16-bit, register-oriented processor into the place where the operand lives. The place is either a register or a memory address. The specifier holds a 3-bit mode in bits [5:3] and a 3-bit register number in bits [2:0]. The lowest mode bit adds one more level of indirection. When it is needed, the block reads pointer words and index words through a simple request/acknowledge memory port. It reports the final location and presents the one register update the mode implies. A word access at an odd address ends the sequence with a trap pulse instead of completion.

The instruction decoder pulses `start` with the specifier, the byte/word flag and a flat copy of the register file. The highest register is the program counter and the one below it is the stack pointer. Index words are fetched at the program counter, which then moves on by 2. For this reason the immediate, absolute and PC-relative forms come out of the ordinary modes with no special cases. The block leaves the data operation, the instruction fetch and the register file itself to its neighbours.

Top module: `ea_seq`

## Requirements
- R1: Mode 0 completes with `is_reg`=1, `reg_num` equal to the specifier register, no memory read and no write-back.
- R2: Mode 1 completes with `addr` equal to the register contents, no memory read and no write-back.
- R3: Mode 2 completes with `addr` equal to the register contents. It writes back the register plus the step.
- R4: Mode 4 subtracts the step from the register, uses the result as `addr` and writes that result back.
- R5: Modes 3 and 5 read one word at the register contents (mode 3) or at the register minus 2 (mode 5). The word read is `addr`. The register write-back is +2 or -2, whatever the byte flag.
- R6: Mode 6 reads one index word at the PC and writes back PC+2 to register 7. `addr` is the index word plus the register, where a register 7 operand means the advanced PC.
- R7: Mode 7 forms the mode 6 sum, reads one word there, and returns that word as `addr`, with the same PC write-back.
- R8: With register 7, mode 2 returns `addr`=PC and writes back PC+2 (immediate), and mode 6 returns index word + PC + 2 (relative).
- R9: A word access at an odd address raises a one-cycle `trap` with no `done` and no write-back. This covers a word-sized final operand, every pointer fetch and every index fetch. A byte-sized final operand may be odd.
- R10: After reset `done`, `trap` and `mem_req` are low. `done` lasts exactly one cycle, and `wb_en` is only high in that cycle.
- R11: The step of modes 2 and 4 is 2 for word operations and for registers 6 and 7. It is 1 for byte operations on registers 0 to 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin resolving a specifier (sampled while idle) |
| spec | input | 6 | Mode [5:3], register [2:0] |
| byte_op | input | 1 | 1 = byte-sized operand |
| regs_flat | input | 128 | Register file, register n at bits [16n+15:16n] |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is a register (valid with done) |
| reg_num | output | 3 | Operand register number |
| addr | output | 16 | Operand memory address |
| wb_en | output | 1 | Register write-back valid (with done) |
| wb_reg | output | 3 | Register to update |
| wb_val | output | 16 | New register value |
| trap | output | 1 | One-cycle odd-address trap pulse |

## Verification
Suppose the held mode or register number is wrong. Then the next completion shows a wrong `addr`, `wb_reg` or `wb_val`, or the wrong number of read handshakes, within one transaction. A state register stuck in a fetch state shows up as `mem_req` that never drops, which the watchdog catches. A wrong odd-address decision appears as `trap` in place of `done`, or the reverse, on the very cycle the sequence would end. The scoreboard compares every reported field against an independently computed expectation for each specifier, at memory latencies of 0 to 2 cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_IDX  = 2'd1,
        ST_PTR  = 2'd2,
        ST_FIN  = 2'd3
    } ea_state_e;

    typedef enum logic [2:0] {
        M_REG    = 3'd0,
        M_DEF    = 3'd1,
        M_INC    = 3'd2,
        M_INCDEF = 3'd3,
        M_DEC    = 3'd4,
        M_DECDEF = 3'd5,
        M_IDX    = 3'd6,
        M_IDXDEF = 3'd7
    } ea_mode_e;
endpackage

// File: rtl/ea_step.sv
module ea_step #(
    parameter int DW = 16,
    parameter int RN = 3
) (
    input  logic          byte_op,
    input  logic [RN-1:0] rnum,
    output logic [DW-1:0] step
);
    localparam logic [RN-1:0] SP_IDX = RN'((1 << RN) - 2);

    // stack pointer and program counter always move by a full word
    always_comb begin
        if (!byte_op || rnum >= SP_IDX) step = DW'(2);
        else                            step = DW'(1);
    end
endmodule

// File: rtl/ea_align.sv
module ea_align #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic          word,
    output logic          fault
);
    always_comb fault = word & a[0];
endmodule

// File: rtl/ea_seq.sv
module ea_seq
    import ea_pkg::*;
#(
    parameter int DW = 16,
    parameter int RN = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [RN+2:0]      spec,
    input  logic               byte_op,
    input  logic [(1<<RN)*DW-1:0] regs_flat,
    output logic               mem_req,
    output logic [DW-1:0]      mem_addr,
    input  logic               mem_ack,
    input  logic [DW-1:0]      mem_rdata,
    output logic               done,
    output logic               is_reg,
    output logic [RN-1:0]      reg_num,
    output logic [DW-1:0]      addr,
    output logic               wb_en,
    output logic [RN-1:0]      wb_reg,
    output logic [DW-1:0]      wb_val,
    output logic               trap
);
    localparam int            NREG   = 1 << RN;
    localparam logic [RN-1:0] PC_IDX = RN'(NREG - 1);
    localparam logic [DW-1:0] TWO    = DW'(2);

    typedef struct packed {
        ea_state_e     st;
        ea_mode_e      mode;
        logic [RN-1:0] rnum;
        logic          byte_op;
        logic [DW-1:0] base;
        logic [DW-1:0] pc;
        logic [DW-1:0] addr;
        logic          is_reg;
        logic          wb;
        logic [RN-1:0] wb_reg;
        logic [DW-1:0] wb_val;
        logic          trap;
    } ctx_t;

    ctx_t ctx_q, ctx_d;

    logic [RN-1:0] in_rnum;
    ea_mode_e      in_mode;
    logic [DW-1:0] in_base, in_pc, step, cand;
    logic          cand_word, fault;

    assign in_rnum = spec[RN-1:0];
    assign in_mode = ea_mode_e'(spec[RN+2:RN]);
    assign in_base = regs_flat[in_rnum*DW +: DW];
    assign in_pc   = regs_flat[PC_IDX*DW +: DW];

    ea_step #(.DW(DW), .RN(RN)) u_step (
        .byte_op (byte_op),
        .rnum    (in_rnum),
        .step    (step)
    );

    // candidate address for the current step and whether it is a word access
    always_comb begin
        cand      = in_base;
        cand_word = 1'b0;
        unique case (ctx_q.st)
            ST_IDLE: begin
                unique case (in_mode)
                    M_REG:          cand_word = 1'b0;
                    M_DEF, M_INC:   cand_word = !byte_op;
                    M_INCDEF:       cand_word = 1'b1;
                    M_DEC: begin
                        cand      = in_base - step;
                        cand_word = !byte_op;
                    end
                    M_DECDEF: begin
                        cand      = in_base - TWO;
                        cand_word = 1'b1;
                    end
                    default: begin
                        cand      = in_pc;
                        cand_word = 1'b1;
                    end
                endcase
            end
            ST_IDX: begin
                cand      = mem_rdata + ((ctx_q.rnum == PC_IDX) ? (ctx_q.pc + TWO) : ctx_q.base);
                cand_word = (ctx_q.mode == M_IDXDEF) || !ctx_q.byte_op;
            end
            ST_PTR: begin
                cand      = mem_rdata;
                cand_word = !ctx_q.byte_op;
            end
            default: begin
                cand      = in_base;
                cand_word = 1'b0;
            end
        endcase
    end

    ea_align #(.DW(DW)) u_align (
        .a     (cand),
        .word  (cand_word),
        .fault (fault)
    );

    always_comb begin
        ctx_d = ctx_q;
        unique case (ctx_q.st)
            ST_IDLE: begin
                ctx_d.trap   = 1'b0;
                ctx_d.wb     = 1'b0;
                ctx_d.is_reg = 1'b0;
                if (start) begin
                    ctx_d.mode    = in_mode;
                    ctx_d.rnum    = in_rnum;
                    ctx_d.byte_op = byte_op;
                    ctx_d.base    = in_base;
                    ctx_d.pc      = in_pc;
                    ctx_d.addr    = cand;
                    ctx_d.trap    = fault;
                    ctx_d.wb_reg  = in_rnum;
                    ctx_d.st      = ST_FIN;
                    unique case (in_mode)
                        M_REG: ctx_d.is_reg = 1'b1;
                        M_DEF: ctx_d.wb = 1'b0;
                        M_INC: begin
                            ctx_d.wb     = 1'b1;
                            ctx_d.wb_val = in_base + step;
                        end
                        M_INCDEF: begin
                            ctx_d.wb     = 1'b1;
                            ctx_d.wb_val = in_base + TWO;
                            if (!fault) ctx_d.st = ST_PTR;
                        end
                        M_DEC: begin
                            ctx_d.wb     = 1'b1;
                            ctx_d.wb_val = cand;
                        end
                        M_DECDEF: begin
                            ctx_d.wb     = 1'b1;
                            ctx_d.wb_val = cand;
                            if (!fault) ctx_d.st = ST_PTR;
                        end
                        default: begin
                            ctx_d.wb     = 1'b1;
                            ctx_d.wb_reg = PC_IDX;
                            ctx_d.wb_val = in_pc + TWO;
                            if (!fault) ctx_d.st = ST_IDX;
                        end
                    endcase
                end
            end
            ST_IDX: begin
                if (mem_ack) begin
                    ctx_d.addr = cand;
                    ctx_d.trap = fault;
                    ctx_d.st   = (ctx_q.mode == M_IDXDEF && !fault) ? ST_PTR : ST_FIN;
                end
            end
            ST_PTR: begin
                if (mem_ack) begin
                    ctx_d.addr = cand;
                    ctx_d.trap = fault;
                    ctx_d.st   = ST_FIN;
                end
            end
            default: ctx_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign mem_req  = (ctx_q.st == ST_IDX) || (ctx_q.st == ST_PTR);
    assign mem_addr = ctx_q.addr;
    assign done     = (ctx_q.st == ST_FIN) && !ctx_q.trap;
    assign trap     = (ctx_q.st == ST_FIN) && ctx_q.trap;
    assign is_reg   = ctx_q.is_reg;
    assign reg_num  = ctx_q.rnum;
    assign addr     = ctx_q.addr;
    assign wb_en    = done && ctx_q.wb;
    assign wb_reg   = ctx_q.wb_reg;
    assign wb_val   = ctx_q.wb_val;

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_end_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || trap) |=> !(done || trap));

    assert_reg_nowb_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_reg) |-> !wb_en);

    assert_trap_nowb_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> !wb_en);

    assert_idle_after_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done || trap) |=> !mem_req);
endmodule

// File: tb/ea_seq_tb.sv
module ea_seq_tb;
    logic         clk = 0;
    logic         rst_n = 0;
    logic         start = 0;
    logic [5:0]   spec = '0;
    logic         byte_op = 0;
    logic [127:0] regs_flat;
    logic         mem_req;
    logic [15:0]  mem_addr;
    logic         mem_ack = 0;
    logic [15:0]  mem_rdata = '0;
    logic         done, is_reg, wb_en, trap;
    logic [2:0]   reg_num, wb_reg;
    logic [15:0]  addr, wb_val;

    logic [15:0] R [8];
    int checks = 0, errors = 0;
    int reads = 0, wait_cnt = 0, lat = 0;
    logic [15:0] ovr_a = 16'hFFFF, ovr_v = '0;
    bit finished = 0;

    typedef struct {
        string       tag;
        bit          etrap;
        bit          eis_reg;
        logic [2:0]  ereg;
        logic [15:0] eaddr;
        bit          ewb;
        logic [2:0]  ewb_reg;
        logic [15:0] ewb_val;
        int          ereads;
    } item_t;
    item_t sb [$];

    always #10 clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) regs_flat[i*16 +: 16] = R[i];
    end

    ea_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
        .regs_flat(regs_flat), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .is_reg(is_reg),
        .reg_num(reg_num), .addr(addr), .wb_en(wb_en), .wb_reg(wb_reg),
        .wb_val(wb_val), .trap(trap)
    );

    function automatic logic [15:0] memf(input logic [15:0] a);
        if (a == ovr_a) return ovr_v;
        return (a + 16'h0200) ^ 16'h0040;
    endfunction

    // memory model with programmable latency
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 0;
        else if (mem_req) begin
            if (wait_cnt >= lat) begin
                mem_rdata = memf(mem_addr);
                mem_ack   = 1;
                wait_cnt  = 0;
                reads++;
            end else wait_cnt++;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // monitor: pops and compares on every completion or trap
    always @(negedge clk) begin
        if (rst_n && (done || trap)) begin
            if (sb.size() == 0) chk(0, "R10", "unexpected end", 16'(done), 16'h0);
            else begin
                item_t it;
                it = sb.pop_front();
                chk(trap == it.etrap, it.tag, "trap", 16'(trap), 16'(it.etrap));
                chk(done == !it.etrap, it.tag, "done", 16'(done), 16'(!it.etrap));
                chk(reads == it.ereads, it.tag, "reads", 16'(reads), 16'(it.ereads));
                if (it.etrap) chk(wb_en == 0, it.tag, "wb_en on trap", 16'(wb_en), 16'h0);
                else begin
                    chk(is_reg == it.eis_reg, it.tag, "is_reg", 16'(is_reg), 16'(it.eis_reg));
                    if (it.eis_reg) chk(reg_num == it.ereg, it.tag, "reg_num", 16'(reg_num), 16'(it.ereg));
                    else chk(addr == it.eaddr, it.tag, "addr", addr, it.eaddr);
                    chk(wb_en == it.ewb, it.tag, "wb_en", 16'(wb_en), 16'(it.ewb));
                    if (it.ewb) begin
                        chk(wb_reg == it.ewb_reg, it.tag, "wb_reg", 16'(wb_reg), 16'(it.ewb_reg));
                        chk(wb_val == it.ewb_val, it.tag, "wb_val", wb_val, it.ewb_val);
                    end
                end
            end
        end
    end

    task automatic run(input logic [5:0] sp, input bit bop, input string tag, input int l);
        item_t it;
        logic [2:0]  m, r;
        logic [15:0] base, pc, st, p, idx, npc, s;
        m = sp[5:3]; r = sp[2:0];
        base = R[r]; pc = R[7];
        st = (!bop || r >= 6) ? 16'd2 : 16'd1;
        it.tag = tag; it.etrap = 0; it.eis_reg = 0; it.ereg = r; it.eaddr = 0;
        it.ewb = 0; it.ewb_reg = r; it.ewb_val = 0; it.ereads = 0;
        case (m)
            3'd0: it.eis_reg = 1;
            3'd1: it.eaddr = base;
            3'd2: begin it.eaddr = base; it.ewb = 1; it.ewb_val = base + st; end
            3'd3: begin
                it.ewb = 1; it.ewb_val = base + 2;
                if (base[0]) it.etrap = 1;
                else begin it.eaddr = memf(base); it.ereads = 1; end
            end
            3'd4: begin p = base - st; it.eaddr = p; it.ewb = 1; it.ewb_val = p; end
            3'd5: begin
                p = base - 2; it.ewb = 1; it.ewb_val = p;
                if (p[0]) it.etrap = 1;
                else begin it.eaddr = memf(p); it.ereads = 1; end
            end
            default: begin
                it.ewb = 1; it.ewb_reg = 3'd7;
                if (pc[0]) it.etrap = 1;
                else begin
                    idx = memf(pc); npc = pc + 2; it.ewb_val = npc; it.ereads = 1;
                    s = idx + ((r == 3'd7) ? npc : base);
                    if (m == 3'd6) it.eaddr = s;
                    else if (s[0]) it.etrap = 1;
                    else begin it.eaddr = memf(s); it.ereads = 2; end
                end
            end
        endcase
        if (m != 0 && !it.etrap && !bop && it.eaddr[0]) it.etrap = 1;
        sb.push_back(it);
        @(negedge clk);
        lat = l; reads = 0; wait_cnt = 0;
        spec = sp; byte_op = bop; start = 1;
        @(negedge clk);
        start = 0;
        while (!(done || trap)) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        R[0] = 16'h1000; R[1] = 16'h2001; R[2] = 16'h3000; R[3] = 16'h0400;
        R[4] = 16'h0500; R[5] = 16'h0600; R[6] = 16'h0800; R[7] = 16'h0100;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(done == 0, "R10", "done at reset", 16'(done), 16'h0);
        chk(trap == 0, "R10", "trap at reset", 16'(trap), 16'h0);
        chk(mem_req == 0, "R10", "mem_req at reset", 16'(mem_req), 16'h0);
        rst_n = 1;
        @(negedge clk);
        run(6'o03, 0, "R1", 0);
        run(6'o03, 1, "R1", 0);
        run(6'o12, 0, "R2", 0);
        run(6'o22, 0, "R3", 0);
        run(6'o22, 1, "R11", 0);
        run(6'o26, 1, "R11", 0);
        run(6'o44, 1, "R11", 0);
        run(6'o40, 0, "R4", 0);
        run(6'o46, 1, "R4", 0);
        run(6'o30, 1, "R5", 1);
        run(6'o53, 1, "R5", 2);
        run(6'o62, 0, "R6", 0);
        run(6'o62, 1, "R6", 2);
        run(6'o70, 0, "R7", 1);
        run(6'o72, 1, "R7", 0);
        run(6'o27, 0, "R8", 0);
        run(6'o67, 0, "R8", 1);
        run(6'o11, 0, "R9", 0);
        run(6'o11, 1, "R9", 0);
        run(6'o31, 1, "R9", 0);
        ovr_a = 16'h03FE; ovr_v = 16'h1235;
        run(6'o53, 0, "R9", 1);
        run(6'o53, 1, "R9", 0);
        ovr_a = 16'hFFFF;
        R[7] = 16'h0101;
        run(6'o62, 0, "R9", 0);
        R[7] = 16'h0100;
        repeat (3) @(negedge clk);
        chk(sb.size() == 0, "R10", "pending items", 16'(sb.size()), 16'h0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R10 watchdog actual=%h expected=%h", 16'h1, 16'h0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule